// File: doc/BRIEF.md
# Flagged Increment and Complement Adder

This block is a purely combinational binary adder of parameterised width (16 bits by default). Alongside its ordinary carries it derives a flag vector from the propagate signals. Flag bit i is set when every propagate bit below position i is 1, so it marks the bits that an incoming +1 would ripple into. Three control inputs select the result that comes out of the same hardware:

- `increment` forces the carry high at every flagged bit. This adds one without a second carry chain.
- `complement` inverts the propagate bits ahead of the final sum XOR. This yields the bitwise complement of the result.
- `subtract` inverts operand B, which turns the sum family into the difference family.

There is no carry input. Results wrap modulo 2^WIDTH and no overflow indication is produced.

Carries come from a network built on 2-bit groups. Each group forms its own generate term from the operand bits and chains the carry in from the group below it. The carry output is the carry out of the most significant bit after the increment override. It does not depend on `complement`.

Top module: `flag_adder`

## Requirements
- R1: With subtract=0, complement=0, increment=0, sum_o equals (in_a + in_b) mod 2^WIDTH.
- R2: With subtract=0, complement=0, increment=1, sum_o equals (in_a + in_b + 1) mod 2^WIDTH.
- R3: With subtract=0, complement=1, increment=0, sum_o equals the bitwise inverse of (in_a + in_b) mod 2^WIDTH, which is -(A+B+1).
- R4: With subtract=0, complement=1, increment=1, sum_o equals the bitwise inverse of (in_a + in_b + 1) mod 2^WIDTH, which is -(A+B+2).
- R5: With subtract=1, operand B is inverted bitwise. The four complement/increment settings 0/0, 0/1, 1/0 and 1/1 then give A-B-1, A-B, B-A and B-A-1 respectively, each modulo 2^WIDTH.
- R6: cout_o equals bit WIDTH of the exact sum in_a + B' + increment, where B' is in_b or its inverse per subtract. The complement input has no effect on cout_o.
- R7: At WIDTH=4 with in_a=0111 and in_b=0101 (subtract=0), the complement/increment settings 0/0, 0/1, 1/0 and 1/1 give 1100, 1101, 0011 and 0010 respectively.
- R8: When every propagate bit is 1 and increment=1, all flags are set. With complement=0 the result is all zeros and cout_o=1; with complement=1 the result is all ones and cout_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand, inverted when subtract=1 |
| subtract | input | 1 | Invert operand B to select the difference family |
| complement | input | 1 | Invert propagate bits to output the ones' complement |
| increment | input | 1 | Force carries at flagged bits to add one |
| sum_o | output | WIDTH | Selected result word |
| cout_o | output | 1 | Carry out of the MSB after the increment override |

## Verification
The bench builds two copies of the block. A 4-bit copy is driven exhaustively: every operand pair, under both subtract values and all four complement/increment settings. At that size every carry-chain length, every flag pattern and the fully propagating case are all reached, as are the odd and even group boundaries.

A second copy at the default 16 bits receives random operands and directed corner cases. These corner cases include all-propagate wraparound and carry-out under both complement values. They exercise chaining across eight 2-bit groups, which the narrow copy cannot reach.

// File: rtl/flag_adder_pkg.sv
package flag_adder_pkg;

    localparam int DEFAULT_WIDTH = 16;

    // Operation selection carried through the datapath
    typedef struct packed {
        logic sub;
        logic comp;
        logic incr;
    } op_ctrl_t;

endpackage

// File: rtl/fa_preproc.sv
module fa_preproc #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] any_o
);

    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff  = b_i ^ {WIDTH{sub_i}};
        prop_o = a_i ^ b_eff;
        gen_o  = a_i & b_eff;
        any_o  = a_i | b_eff;
    end

endmodule

// File: rtl/fa_group_carry.sv
module fa_group_carry #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] any_i,
    output logic [WIDTH:0]   carry_o
);

    localparam int NGRP = WIDTH / 2;
    localparam int ODD  = WIDTH % 2;

    assign carry_o[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < NGRP; k++) begin : g_grp
            localparam int LO = 2 * k;
            logic grp_gen;
            logic grp_prop;
            always_comb begin
                // generate term of the pair, independent of the incoming carry
                grp_gen  = gen_i[LO+1] | (gen_i[LO] & any_i[LO+1]);
                grp_prop = prop_i[LO+1] & prop_i[LO];
            end
            assign carry_o[LO+1] = gen_i[LO] | (prop_i[LO] & carry_o[LO]);
            assign carry_o[LO+2] = grp_gen | (grp_prop & carry_o[LO]);
        end
        if (ODD != 0) begin : g_tail
            assign carry_o[WIDTH] = gen_i[WIDTH-1] | (prop_i[WIDTH-1] & carry_o[WIDTH-1]);
        end
    endgenerate

    // R1: a generating bit always carries out; a killing bit never does
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            if (gen_i[i])
                p_gen_carries_r1: assert (carry_o[i+1]);
            if (!prop_i[i] && !gen_i[i])
                p_kill_blocks_r1: assert (!carry_o[i+1]);
        end
    end

endmodule

// File: rtl/fa_flag_gen.sv
module fa_flag_gen #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] prop_i,
    output logic [WIDTH:0]   flag_o
);

    always_comb begin
        flag_o[0] = 1'b1;
        for (int i = 1; i <= WIDTH; i++) begin
            flag_o[i] = flag_o[i-1] & prop_i[i-1];
        end
    end

    // R2: flags form a thermometer from the LSB upward
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            if (flag_o[i+1])
                p_flag_thermo_r2: assert (flag_o[i]);
        end
    end

endmodule

// File: rtl/fa_post.sv
module fa_post #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH:0]   carry_i,
    input  logic [WIDTH:0]   flag_i,
    input  logic             comp_i,
    input  logic             incr_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0]   carry_eff;
    logic [WIDTH-1:0] prop_sel;

    always_comb begin
        carry_eff = carry_i | (flag_i & {(WIDTH+1){incr_i}});
        prop_sel  = prop_i ^ {WIDTH{comp_i}};
        sum_o     = prop_sel ^ carry_eff[WIDTH-1:0];
        cout_o    = carry_eff[WIDTH];
    end

    // R2 / R3: the LSB has no carry in, so only the controls shape it
    always_comb begin
        if (!comp_i && incr_i)
            p_incr_lsb_r2: assert (sum_o[0] == ~prop_i[0]);
        if (comp_i && !incr_i)
            p_comp_lsb_r3: assert (sum_o[0] == ~prop_i[0]);
    end

endmodule

// File: rtl/flag_adder.sv
module flag_adder
    import flag_adder_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             subtract,
    input  logic             complement,
    input  logic             increment,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    op_ctrl_t         ctrl;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] any;
    logic [WIDTH:0]   carry;
    logic [WIDTH:0]   flag;

    always_comb begin
        ctrl.sub  = subtract;
        ctrl.comp = complement;
        ctrl.incr = increment;
    end

    fa_preproc #(.WIDTH(WIDTH)) i_pre (
        .a_i    (in_a),
        .b_i    (in_b),
        .sub_i  (ctrl.sub),
        .prop_o (prop),
        .gen_o  (gen),
        .any_o  (any)
    );

    fa_group_carry #(.WIDTH(WIDTH)) i_carry (
        .prop_i  (prop),
        .gen_i   (gen),
        .any_i   (any),
        .carry_o (carry)
    );

    fa_flag_gen #(.WIDTH(WIDTH)) i_flag (
        .prop_i (prop),
        .flag_o (flag)
    );

    fa_post #(.WIDTH(WIDTH)) i_post (
        .prop_i  (prop),
        .carry_i (carry),
        .flag_i  (flag),
        .comp_i  (ctrl.comp),
        .incr_i  (ctrl.incr),
        .sum_o   (sum_o),
        .cout_o  (cout_o)
    );

    // R8: fully propagating word plus one wraps to zero (or all ones when inverted)
    always_comb begin
        if (&prop && increment) begin
            p_wrap_all_r8: assert (cout_o && (sum_o == {WIDTH{complement}}));
        end
    end

endmodule

// File: tb/test_flag_adder.sv
module test_flag_adder;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [15:0] a16, b16, s16;
    logic        sub16, comp16, inc16, c16;
    logic [3:0]  a4, b4, s4;
    logic        sub4, comp4, inc4, c4;

    flag_adder #(.WIDTH(16)) i_flag_adder (
        .in_a(a16), .in_b(b16), .subtract(sub16), .complement(comp16),
        .increment(inc16), .sum_o(s16), .cout_o(c16)
    );

    flag_adder #(.WIDTH(4)) i_flag_adder_w4 (
        .in_a(a4), .in_b(b4), .subtract(sub4), .complement(comp4),
        .increment(inc4), .sum_o(s4), .cout_o(c4)
    );

    // expected {cout, result} from the requirement text
    function automatic logic [16:0] model(int w, logic [15:0] a, logic [15:0] b,
                                          logic s, logic c, logic i);
        logic [16:0] mask;
        logic [16:0] bb;
        logic [16:0] tot;
        logic [16:0] res;
        mask = (17'd1 << w) - 17'd1;
        bb   = s ? ({1'b0, ~b} & mask) : {1'b0, b};
        tot  = {1'b0, a} + bb + {16'd0, i};
        res  = c ? (~tot & mask) : (tot & mask);
        return {tot[w], res[15:0]};
    endfunction

    function automatic string tag_of(logic s, logic c, logic i);
        if (s) return "R5";
        if (c) return i ? "R4" : "R3";
        return i ? "R2" : "R1";
    endfunction

    task automatic cmp(string tag, logic [16:0] act, logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply16(logic [15:0] a, logic [15:0] b, logic s, logic c, logic i);
        logic [16:0] e;
        @(posedge clk);
        #1;
        a16 = a; b16 = b; sub16 = s; comp16 = c; inc16 = i;
        @(negedge clk);
        e = model(16, a, b, s, c, i);
        cmp(tag_of(s, c, i), {1'b0, s16}, {1'b0, e[15:0]});
        cmp("R6", {16'd0, c16}, {16'd0, e[16]});
    endtask

    task automatic apply4(logic [3:0] a, logic [3:0] b, logic s, logic c, logic i);
        logic [16:0] e;
        @(posedge clk);
        #1;
        a4 = a; b4 = b; sub4 = s; comp4 = c; inc4 = i;
        @(negedge clk);
        e = model(4, {12'd0, a}, {12'd0, b}, s, c, i);
        cmp(tag_of(s, c, i), {13'd0, s4}, {13'd0, e[3:0]});
        cmp("R6", {16'd0, c4}, {16'd0, e[16]});
    endtask

    // idle state: all-zero inputs give a zero result and no carry (R1)
    task automatic t_idle_zero();
        @(negedge clk);
        cmp("R1", {c16, s16}, 17'd0);
        cmp("R1", {12'd0, c4, s4}, 17'd0);
    endtask

    // worked 4-bit example (R7), compared against fixed values
    task automatic t_worked_example();
        logic [3:0] exp [4] = '{4'b1100, 4'b1101, 4'b0011, 4'b0010};
        for (int m = 0; m < 4; m++) begin
            @(posedge clk);
            #1;
            a4 = 4'b0111; b4 = 4'b0101; sub4 = 1'b0;
            comp4 = m[1]; inc4 = m[0];
            @(negedge clk);
            cmp("R7", {13'd0, s4}, {13'd0, exp[m]});
        end
    endtask

    // every operand pair at 4 bits, all controls (R1..R6)
    task automatic t_exhaustive_w4();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int m = 0; m < 8; m++)
                    apply4(a[3:0], b[3:0], m[2], m[1], m[0]);
    endtask

    // random 16-bit operands across all controls (R1..R6)
    task automatic t_random_w16();
        for (int n = 0; n < 500; n++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            for (int m = 0; m < 8; m++)
                apply16(ra, rb, m[2], m[1], m[0]);
        end
    endtask

    // all-propagate wraparound (R8) and carry out independent of complement (R6)
    task automatic t_wrap_boundary();
        apply16(16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b1);
        cmp("R8", {c16, s16}, {1'b1, 16'h0000});
        apply16(16'hA5A5, 16'h5A5A, 1'b0, 1'b1, 1'b1);
        cmp("R8", {c16, s16}, {1'b1, 16'hFFFF});
        apply16(16'h1234, 16'h1234, 1'b1, 1'b0, 1'b1);
        cmp("R8", {c16, s16}, {1'b1, 16'h0000});
        apply16(16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0);
        cmp("R6", {16'd0, c16}, 17'd1);
        apply16(16'hFFFF, 16'h0001, 1'b0, 1'b1, 1'b0);
        cmp("R6", {16'd0, c16}, 17'd1);
        apply16(16'h8000, 16'h7FFF, 1'b0, 1'b1, 1'b0);
        cmp("R6", {16'd0, c16}, 17'd0);
    endtask

    initial begin
        a16 = '0; b16 = '0; sub16 = 0; comp16 = 0; inc16 = 0;
        a4 = '0; b4 = '0; sub4 = 0; comp4 = 0; inc4 = 0;
        repeat (2) @(posedge clk);
        t_idle_zero();
        t_worked_example();
        t_wrap_boundary();
        t_exhaustive_w4();
        t_random_w16();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule